// File: doc/BRIEF.md
# I2C Audio Codec Boot Sequencer

This block brings a slave-only audio codec out of reset by writing a built-in list of ten configuration words to it over a two-wire I2C bus. A one-cycle pulse on `start` begins the run. The block then sends each word as its own write transaction. Each transaction carries the codec's 7-bit bus address with the write flag, followed by the 16-bit word. The word holds a 7-bit register number in its upper bits and 9 bits of register data in its lower bits. The final word switches the codec's audio interface on, so it always goes last.

SCL comes from the system clock through a tick divider. Each data bit takes three ticks: one with SCL low, while SDA may change, then one with SCL high, then one more with SCL low. START and STOP take two ticks each. SDA is open-drain. The block only ever pulls it low, through an output enable. It releases the line in every ninth bit slot and reads the slave's acknowledge from the same pin. If an acknowledge is missing, the block stops the transaction with a STOP, raises `cfg_err` and goes idle. If every word is acknowledged, `done` rises after the last STOP.

Top module: `codec_boot_seq`

## Requirements
- R1: Out of reset and whenever `busy` is low, SCL is high, SDA is released (reads high through the pull-up), and `busy`, `done` and `cfg_err` are low.
- R2: Each transaction is a START, then 27 SCL pulses, then a STOP. The 27 pulses are: address byte 0011010 followed by write flag 0, an acknowledge slot, word bits [15:8] MSB first, an acknowledge slot, word bits [7:0] MSB first, and an acknowledge slot.
- R3: The words go out in this fixed order: 0x0097, 0x0297, 0x0479, 0x0679, 0x0815, 0x0A00, 0x0C00, 0x0E42, 0x1019, 0x1201. Word n carries register number n in bits [15:9].
- R4: Inside a transaction, SDA holds its value for the whole time SCL is high. SDA changes while SCL is high only for START (falling) and STOP (rising).
- R5: Every SCL high time is exactly TICK_DIV clocks. Successive data-bit rising edges are exactly 3*TICK_DIV clocks apart, which gives 500 kHz from 12 MHz at the default of 8.
- R6: The block does not drive SDA in any acknowledge slot, so the slave's level is what is read.
- R7: If an acknowledge slot reads high, that transaction ends with a STOP straight after the slot, no further transaction starts, `cfg_err` goes high and `done` stays low.
- R8: Between one STOP and the next START, the bus stays idle for at least 3*TICK_DIV clocks.
- R9: `busy` is high from the clock after an accepted `start` until the run ends. A `start` pulse while `busy` is high is ignored.
- R10: An accepted `start` clears `done` and `cfg_err` and restarts from the first word. After `done`, `busy` is low, `done` is high and exactly ten transactions have been sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the boot list |
| scl | output | 1 | Bus clock |
| sda | inout | 1 | Bus data, open-drain (driven low or high-impedance) |
| busy | output | 1 | Run in progress |
| done | output | 1 | All ten words acknowledged |
| cfg_err | output | 1 | A missing acknowledge ended the run |

## Verification
A wrong word index or a wrong shift position shows up as a bad byte in the first transaction it touches, within about 90 ticks. A bad phase counter shows up one bit later as a stretched SCL high time or as SDA moving while SCL is high. If the acknowledge slot is decoded wrongly, SDA is driven during the slot. That shows up either as a missed NACK when the slave stays silent, or as a premature abort. Each case is visible on the very transaction where it happens. A sequencer that loses track of the end of the list sends a wrong number of transactions, raises `done` at the wrong time, or raises `done` together with `cfg_err`.

// File: rtl/codec_boot_pkg.sv
package codec_boot_pkg;
  localparam int NUM_WORDS = 10;
  localparam int FRAME_W   = 24;
  localparam logic [6:0] CODEC_ADDR = 7'b0011010;

  typedef enum logic [2:0] {
    BUS_IDLE, BUS_START, BUS_BIT, BUS_STOP, BUS_GAP
  } bus_state_t;

  // register number equals list position; only the 9-bit payload varies
  function automatic logic [15:0] boot_word(input int unsigned idx);
    logic [8:0] payload;
    case (idx)
      0, 1:    payload = 9'h097;
      2, 3:    payload = 9'h079;
      4:       payload = 9'h015;
      7:       payload = 9'h042;
      8:       payload = 9'h019;
      9:       payload = 9'h001;
      default: payload = 9'h000;
    endcase
    return {idx[6:0], payload};
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input logic [15:0] w);
    return {CODEC_ADDR, 1'b0, w};
  endfunction
endpackage

// File: rtl/boot_tick_gen.sv
module boot_tick_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr | tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_write_engine.sv
module i2c_write_engine
  import codec_boot_pkg::*;
#(
  parameter int NBYTES    = 3,
  parameter int GAP_TICKS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  go,
  input  logic [NBYTES*8-1:0]   frame,
  input  logic                  sda_in,
  output logic                  scl,
  output logic                  sda_oe,
  output logic                  idle,
  output logic                  xfer_done,
  output logic                  nack
);
  localparam int FW  = NBYTES * 8;
  localparam int BCW = (NBYTES > 2) ? $clog2(NBYTES) : 1;
  localparam int GCW = (GAP_TICKS > 2) ? $clog2(GAP_TICKS) : 1;

  bus_state_t     state;
  logic [1:0]     ph;
  logic [3:0]     bitn;
  logic [BCW-1:0] byten;
  logic [GCW-1:0] gapc;
  logic [FW-1:0]  shreg;
  logic           nack_q;

  // named internal events
  logic ack_slot, ack_sample, last_byte, bit_end;
  assign ack_slot   = (state == BUS_BIT) && (bitn == 4'd8);
  assign ack_sample = tick && ack_slot && (ph == 2'd1);
  assign last_byte  = (byten == BCW'(NBYTES - 1));
  assign bit_end    = tick && (state == BUS_BIT) && (ph == 2'd2);
  assign xfer_done  = tick && (state == BUS_GAP) && (gapc == GCW'(GAP_TICKS - 1));
  assign idle       = (state == BUS_IDLE);
  assign nack       = nack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= BUS_IDLE;
      ph     <= '0;
      bitn   <= '0;
      byten  <= '0;
      gapc   <= '0;
      shreg  <= '0;
      nack_q <= 1'b0;
    end else begin
      case (state)
        BUS_IDLE: if (go) begin
          state  <= BUS_START;
          ph     <= '0;
          bitn   <= '0;
          byten  <= '0;
          shreg  <= frame;
          nack_q <= 1'b0;
        end
        BUS_START: if (tick) begin
          if (ph == 2'd0) ph <= 2'd1;
          else begin
            state <= BUS_BIT;
            ph    <= '0;
          end
        end
        BUS_BIT: if (tick) begin
          case (ph)
            2'd0: ph <= 2'd1;
            2'd1: begin
              ph <= 2'd2;
              if (ack_slot && sda_in) nack_q <= 1'b1;
            end
            default: begin
              ph <= 2'd0;
              if (ack_slot) begin
                bitn <= '0;
                if (nack_q || last_byte) state <= BUS_STOP;
                else                     byten <= byten + 1'b1;
              end else begin
                bitn  <= bitn + 1'b1;
                shreg <= {shreg[FW-2:0], 1'b0};
              end
            end
          endcase
        end
        BUS_STOP: if (tick) begin
          if (ph == 2'd0) ph <= 2'd1;
          else begin
            state <= BUS_GAP;
            gapc  <= '0;
            ph    <= '0;
          end
        end
        BUS_GAP: if (tick) begin
          if (gapc == GCW'(GAP_TICKS - 1)) state <= BUS_IDLE;
          else                             gapc  <= gapc + 1'b1;
        end
        default: state <= BUS_IDLE;
      endcase
    end
  end

  always_comb begin
    scl    = 1'b1;
    sda_oe = 1'b0;
    case (state)
      BUS_START: begin scl = (ph == 2'd0); sda_oe = 1'b1; end
      BUS_BIT:   begin scl = (ph == 2'd1); sda_oe = (bitn != 4'd8) && !shreg[FW-1]; end
      BUS_STOP:  begin scl = (ph == 2'd1); sda_oe = 1'b1; end
      default:   begin scl = 1'b1; sda_oe = 1'b0; end
    endcase
  end

  AST_SDA_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BUS_BIT && scl && $past(scl)) |-> $stable(sda_oe)); // R4

  AST_NACK_TO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && nack_q) |=> (state == BUS_STOP)); // R7
endmodule

// File: rtl/codec_boot_seq.sv
module codec_boot_seq
  import codec_boot_pkg::*;
#(
  parameter int TICK_DIV  = 8,
  parameter int GAP_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic scl,
  inout  wire  sda,
  output logic busy,
  output logic done,
  output logic cfg_err
);
  localparam int IW = (NUM_WORDS > 2) ? $clog2(NUM_WORDS) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_WORDS - 1);

  logic          tick, go_q, eng_idle, xfer_done, eng_nack, sda_oe, sda_in;
  logic [IW-1:0] idx;
  logic          busy_q, done_q, err_q;
  logic [FRAME_W-1:0] frame;

  assign frame  = build_frame(boot_word(32'(idx)));
  assign sda    = sda_oe ? 1'b0 : 1'bz;
  assign sda_in = sda;

  boot_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(go_q && eng_idle), .tick(tick)
  );

  i2c_write_engine #(.NBYTES(FRAME_W / 8), .GAP_TICKS(GAP_TICKS)) u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(go_q), .frame(frame),
    .sda_in(sda_in), .scl(scl), .sda_oe(sda_oe), .idle(eng_idle),
    .xfer_done(xfer_done), .nack(eng_nack)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      go_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (start && !busy_q) begin
        idx    <= '0;
        go_q   <= 1'b1;
        busy_q <= 1'b1;
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end else if (xfer_done) begin
        if (eng_nack) begin
          err_q  <= 1'b1;
          busy_q <= 1'b0;
        end else if (idx == LAST_IDX) begin
          done_q <= 1'b1;
          busy_q <= 1'b0;
        end else begin
          idx  <= idx + 1'b1;
          go_q <= 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign cfg_err = err_q;

  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (scl && !sda_oe)); // R1

  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && err_q)); // R7

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST_IDX); // R3

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !xfer_done) |=> $stable(idx)); // R9

  AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> eng_idle); // R2
endmodule

// File: tb/test_codec_boot_seq.sv
`timescale 1ns/1ps
module test_codec_boot_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;
  localparam logic [15:0] EXP_WORDS [10] = '{
    16'h0097, 16'h0297, 16'h0479, 16'h0679, 16'h0815,
    16'h0A00, 16'h0C00, 16'h0E42, 16'h1019, 16'h1201};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic scl, busy, done, cfg_err;
  wire  sda_w;
  logic slv_ack = 1'b0;

  pullup (sda_w);
  assign sda_w = slv_ack ? 1'b0 : 1'bz;

  codec_boot_seq #(.TICK_DIV(DIV), .GAP_TICKS(3)) i_codec_boot_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .scl(scl), .sda(sda_w),
    .busy(busy), .done(done), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus monitor and acknowledging slave
  logic p_scl = 1'b1, p_sda = 1'b1;
  bit   in_frame = 0, bit_open = 0, has_pend = 0, seen_stop = 0;
  int   bitcnt = 0, hcnt = 0, since_rise = 0, pend = 0, gapcnt = 0;
  int   nfr = 0, nack_frame = -1, nack_byte = -1;
  int   high_err = 0, per_err = 0, hold_err = 0, gap_err = 0, rstart_err = 0;
  logic sda_rise = 1'b1;
  logic [31:0] shiftr = '0;
  logic [31:0] fr_bits [16];
  int          fr_n    [16];

  always @(negedge clk) begin
    logic s, d;
    s = scl;
    d = sda_w;
    since_rise++;
    gapcnt++;
    if (bit_open && s) hcnt++;
    if (p_scl && s && p_sda && !d) begin
      if (in_frame) rstart_err++;
      if (seen_stop && gapcnt < 3*DIV) gap_err++;
      in_frame = 1; bitcnt = 0; shiftr = '0; bit_open = 0; has_pend = 0;
    end else if (p_scl && s && !p_sda && d) begin
      if (in_frame && nfr < 16) begin
        fr_bits[nfr] = shiftr >> 1;
        fr_n[nfr]    = bitcnt - 1;
        nfr++;
      end
      in_frame = 0; bit_open = 0; seen_stop = 1; gapcnt = 0; slv_ack = 1'b0;
    end else if (!p_scl && s && in_frame) begin
      shiftr = {shiftr[30:0], d};
      bitcnt++;
      if (has_pend && pend != 3*DIV) per_err++;
      if (bitcnt > 1) begin pend = since_rise; has_pend = 1; end
      since_rise = 0; bit_open = 1; hcnt = 1; sda_rise = d;
    end else if (p_scl && !s && in_frame && bit_open) begin
      if (hcnt != DIV) high_err++;
      if (d != sda_rise) hold_err++;
      bit_open = 0;
      if (bitcnt % 9 == 8)
        slv_ack = !((nfr == nack_frame) && (bitcnt / 9 == nack_byte));
      else if (bitcnt % 9 == 0)
        slv_ack = 1'b0;
    end
    p_scl = s;
    p_sda = d;
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, req, n, 20000);
  endtask

  function automatic logic [26:0] exp_frame(input logic [15:0] w);
    return {7'b0011010, 1'b0, 1'b0, w[15:8], 1'b0, w[7:0], 1'b0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(scl === 1'b1,   "R1 scl", scl, 1);
    chk(sda_w === 1'b1, "R1 sda", sda_w, 1);
    chk({busy, done, cfg_err} === 3'b000, "R1 flags", {busy, done, cfg_err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(scl === 1'b1 && sda_w === 1'b1, "R1 idle after reset", {scl, sda_w}, 3);

    // full run
    nfr = 0;
    pulse_start();
    chk(busy === 1'b1, "R9 busy after start", busy, 1);
    repeat (1500) @(negedge clk);
    pulse_start(); // R9: ignored while busy
    wait_idle("R10 run finishes");
    chk(done === 1'b1 && cfg_err === 1'b0, "R10 done set", {done, cfg_err}, 2);
    chk(nfr == 10, "R10 transaction count", nfr, 10);
    for (int i = 0; i < 10; i++) begin
      chk(fr_n[i] == 27, "R2 pulses per transaction", fr_n[i], 27);
      chk(fr_bits[i][26:0] == exp_frame(EXP_WORDS[i]), "R3 word order/content",
          fr_bits[i][26:0], exp_frame(EXP_WORDS[i]));
    end
    chk(hold_err == 0 && rstart_err == 0, "R4 SDA stable while SCL high", hold_err, 0);
    chk(high_err == 0, "R5 SCL high time", high_err, 0);
    chk(per_err == 0, "R5 SCL bit period", per_err, 0);
    chk(gap_err == 0, "R8 idle gap", gap_err, 0);

    // NACK on the register byte of the fourth transaction
    nfr = 0; nack_frame = 3; nack_byte = 1;
    pulse_start();
    chk(done === 1'b0, "R10 start clears done", done, 0);
    wait_idle("R7 abort finishes");
    chk(cfg_err === 1'b1 && done === 1'b0, "R7 error flag", {done, cfg_err}, 1);
    chk(nfr == 4, "R7 no further transaction", nfr, 4);
    chk(fr_n[3] == 18, "R7 stop after slot", fr_n[3], 18);
    chk(fr_bits[3][0] == 1'b1, "R6 SDA released in ack slot", fr_bits[3][0], 1);
    chk(fr_bits[3][8:1] == EXP_WORDS[3][15:8], "R7 partial byte", fr_bits[3][8:1], EXP_WORDS[3][15:8]);
    repeat (2000) @(negedge clk);
    chk(nfr == 4 && scl === 1'b1 && sda_w === 1'b1, "R7 bus stays idle", nfr, 4);

    // restart after error
    nfr = 0; nack_frame = -1; nack_byte = -1;
    pulse_start();
    chk(cfg_err === 1'b0, "R10 start clears cfg_err", cfg_err, 0);
    wait_idle("R10 rerun finishes");
    chk(done === 1'b1 && nfr == 10, "R10 rerun complete", nfr, 10);
    chk(fr_bits[9][26:0] == exp_frame(16'h1201), "R3 activation word last",
        fr_bits[9][26:0], exp_frame(16'h1201));
    chk(hold_err == 0 && high_err == 0 && per_err == 0 && gap_err == 0,
        "R4 R5 R8 timing over all runs", hold_err + high_err + per_err + gap_err, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule